// File: doc/BRIEF.md
# Predicated Lockstep Processing-Element Array

This block is a row of processing elements (lanes) that all obey one shared instruction stream. An external sequencer issues one decoded instruction per cycle on a broadcast port. Every lane that is currently enabled executes that instruction on its own state. That state is an accumulator, a small file of data registers, an index register and a private local memory. The lanes hold no program counter. The only per-lane control is an enable bit, the predicate, which instructions can clear and which a dedicated instruction can set again.

Local memory is always addressed through the lane's own index register. One broadcast load or store can therefore reach a different word in every lane. A host port reaches the memory of any lane, selected by lane number and word address. The host port is used to preload operands and to collect results. Divergent work is expressed by narrowing the set of enabled lanes, never by giving lanes separate instructions.

Top module: `simt_pe_array`

## Requirements
- R1: After reset every lane is enabled, and its accumulator, index register and all data registers read zero.
- R2: An enabled lane given a valid instruction updates its state at the next clock edge. The opcodes on `ins_op` are: 0 no-op; 1 load `ins_imm` into the accumulator; 4 add data register `ins_sel` to the accumulator; 5 subtract data register `ins_sel` from the accumulator; 6 copy the accumulator into data register `ins_sel`. Arithmetic wraps modulo 2^DATA_W, and codes 11 to 15 act as no-ops.
- R3: Opcode 7 loads the index register from the low bits of `ins_imm`. Opcode 8 adds the low bits of `ins_imm` to it. Both wrap modulo MEM_DEPTH, which is a power of two.
- R4: Opcode 2 loads the accumulator from the lane's local memory at its own index. Opcode 3 stores the accumulator there. The same instruction thus reaches different addresses in different lanes.
- R5: A disabled lane ignores every opcode except 10. Its accumulator, index, data registers, memory and enable bit stay unchanged.
- R6: Opcode 9 (compare-and-mask) sets the enable bit of each enabled lane from a test of its accumulator, chosen by `ins_imm[1:0]`: 0 equal to zero, 1 not zero, 2 negative (two's complement), 3 greater than zero. Lanes that are already disabled stay disabled.
- R7: Opcode 10 enables every lane, whatever its enable bit was.
- R8: With `host_en` and `host_we` high, `host_wdata` is written to word `host_addr` of lane `host_lane`. With `host_en` high and `host_we` low, that word appears on `host_rdata` one cycle later, as it was before the request edge. Without a host read, `host_rdata` holds its value.
- R9: When a host write and a broadcast store hit the same lane in the same cycle, the host write is performed and that lane's store is dropped. Stores in the other lanes proceed.
- R10: With `ins_valid` low, no lane changes its accumulator, index or enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Broadcast instruction present this cycle |
| ins_op | input | 4 | Broadcast opcode |
| ins_sel | input | log2(NREG) | Data register selector |
| ins_imm | input | DATA_W | Immediate operand |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_lane | input | log2(LANES) | Lane selected by the host |
| host_addr | input | log2(MEM_DEPTH) | Word address in the selected lane |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, one cycle after the request |
| lane_acc | output | LANES*DATA_W | Accumulators, lane 0 in the low bits |
| lane_idx | output | LANES*log2(MEM_DEPTH) | Index registers, lane 0 in the low bits |
| lane_active | output | LANES | Enable bits, bit n for lane n |

## Verification
The bench builds the array with 4 lanes of 16 bits, 8 memory words per lane and 4 data registers. This keeps every memory word of every lane within reach of a full host write and read-back sweep. It also lets one-hot masks be built for each lane in turn, so every lane gets a distinct index. Add and subtract are swept over all pairs of a value set that spans zero, one, the sign boundary and all-ones. Compare-and-mask is swept over every test code against the same set. Nested masking and the store-versus-host collision are exercised with lane-specific data.

// File: rtl/simt_pkg.sv
package simt_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LDI   = 4'd1,
    OP_LDM   = 4'd2,
    OP_STM   = 4'd3,
    OP_ADD   = 4'd4,
    OP_SUB   = 4'd5,
    OP_MOVR  = 4'd6,
    OP_SETX  = 4'd7,
    OP_ADDX  = 4'd8,
    OP_CMPM  = 4'd9,
    OP_ALLON = 4'd10
  } op_e;

endpackage

// File: rtl/pe_lane.sv
module pe_lane
  import simt_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 16,
  parameter int NREG      = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ins_valid,
  input  op_e                          ins_op,
  input  logic [$clog2(NREG)-1:0]      ins_sel,
  input  logic [DATA_W-1:0]            ins_imm,
  input  logic                         host_wr,
  input  logic [$clog2(MEM_DEPTH)-1:0] host_addr,
  input  logic [DATA_W-1:0]            host_wdata,
  output logic [DATA_W-1:0]            acc,
  output logic [$clog2(MEM_DEPTH)-1:0] idx,
  output logic                         active,
  output logic [DATA_W-1:0]            rd_word
);
  localparam int AW = $clog2(MEM_DEPTH);

  function automatic logic [DATA_W-1:0] wrap_arith(input logic [DATA_W-1:0] a,
                                                   input logic [DATA_W-1:0] b,
                                                   input logic sub);
    return sub ? (a - b) : (a + b);
  endfunction

  function automatic logic lane_test(input logic [1:0] code, input logic [DATA_W-1:0] v);
    logic hit;
    case (code)
      2'd0:    hit = (v == '0);
      2'd1:    hit = (v != '0);
      2'd2:    hit = v[DATA_W-1];
      default: hit = !v[DATA_W-1] && (v != '0);
    endcase
    return hit;
  endfunction

  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] mem  [MEM_DEPTH];

  // named internal events for the checks below
  logic fire, st_req, st_en, st_blocked, wake;
  assign fire       = ins_valid && active;
  assign st_req     = fire && (ins_op == OP_STM);
  assign st_blocked = st_req && host_wr;
  assign st_en      = st_req && !host_wr;
  assign wake       = ins_valid && (ins_op == OP_ALLON);
  assign rd_word    = mem[host_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      idx    <= '0;
      active <= 1'b1;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (fire) begin
        case (ins_op)
          OP_LDI:  acc <= ins_imm;
          OP_LDM:  acc <= mem[idx];
          OP_ADD:  acc <= wrap_arith(acc, regs[ins_sel], 1'b0);
          OP_SUB:  acc <= wrap_arith(acc, regs[ins_sel], 1'b1);
          OP_MOVR: regs[ins_sel] <= acc;
          OP_SETX: idx <= ins_imm[AW-1:0];
          OP_ADDX: idx <= idx + ins_imm[AW-1:0];
          OP_CMPM: active <= lane_test(ins_imm[1:0], acc);
          default: ;
        endcase
      end
      if (wake) active <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (host_wr)    mem[host_addr] <= host_wdata;
    else if (st_en) mem[idx]       <= acc;
  end

  // R5: a disabled lane holds its state unless woken
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !active && ins_op != OP_ALLON) |=> ($stable(acc) && $stable(idx) && !active));

  // R10: no instruction, no change
  assert_no_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> ($stable(acc) && $stable(idx) && $stable(active)));

  // R7: wake-all enables the lane
  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> active);

  // R2: immediate load lands in the next cycle
  assert_ldi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_op == OP_LDI) |=> (acc == $past(ins_imm)));

  // R9: host write wins over a colliding store
  assert_host_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_blocked |=> (mem[$past(host_addr)] == $past(host_wdata)));

endmodule

// File: rtl/host_read_port.sv
module host_read_port #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_req,
  input  logic [$clog2(LANES)-1:0]  lane_sel,
  input  logic [LANES*DATA_W-1:0]   words,
  output logic [DATA_W-1:0]         rdata
);
  function automatic logic [DATA_W-1:0] pick(input logic [LANES*DATA_W-1:0] w,
                                             input logic [$clog2(LANES)-1:0] s);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++)
      if (s == i[$clog2(LANES)-1:0]) r = w[i*DATA_W +: DATA_W];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_req) rdata <= pick(words, lane_sel);
  end

  // R8: read data only moves on a read request
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rdata));

endmodule

// File: rtl/simt_pe_array.sv
module simt_pe_array
  import simt_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 16,
  parameter int NREG      = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 ins_valid,
  input  logic [3:0]                           ins_op,
  input  logic [$clog2(NREG)-1:0]              ins_sel,
  input  logic [DATA_W-1:0]                    ins_imm,
  input  logic                                 host_en,
  input  logic                                 host_we,
  input  logic [$clog2(LANES)-1:0]             host_lane,
  input  logic [$clog2(MEM_DEPTH)-1:0]         host_addr,
  input  logic [DATA_W-1:0]                    host_wdata,
  output logic [DATA_W-1:0]                    host_rdata,
  output logic [LANES*DATA_W-1:0]              lane_acc,
  output logic [LANES*$clog2(MEM_DEPTH)-1:0]   lane_idx,
  output logic [LANES-1:0]                     lane_active
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int LW = $clog2(LANES);

  op_e                     op;
  logic [LANES*DATA_W-1:0] rd_words;
  logic                    host_rd;

  assign op      = op_e'(ins_op);
  assign host_rd = host_en && !host_we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic host_wr_g;
    assign host_wr_g = host_en && host_we && (host_lane == LW'(g));
    pe_lane #(
      .DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH), .NREG(NREG)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_valid (ins_valid),
      .ins_op    (op),
      .ins_sel   (ins_sel),
      .ins_imm   (ins_imm),
      .host_wr   (host_wr_g),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .acc       (lane_acc[g*DATA_W +: DATA_W]),
      .idx       (lane_idx[g*AW +: AW]),
      .active    (lane_active[g]),
      .rd_word   (rd_words[g*DATA_W +: DATA_W])
    );
  end

  host_read_port #(.LANES(LANES), .DATA_W(DATA_W)) u_host (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (host_rd),
    .lane_sel(host_lane),
    .words   (rd_words),
    .rdata   (host_rdata)
  );

  // R6: compare-and-mask can never enable a lane that was disabled
  assert_mask_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && op == OP_CMPM) |=> ((lane_active & ~$past(lane_active)) == '0));

endmodule

// File: tb/simt_pe_array_test.sv
module simt_pe_array_test;
  localparam int L = 4, W = 16, D = 8, NR = 4;

  logic clk = 0, rst_n = 0;
  logic ins_valid = 0;
  logic [3:0] ins_op = 0;
  logic [1:0] ins_sel = 0;
  logic [W-1:0] ins_imm = 0;
  logic host_en = 0, host_we = 0;
  logic [1:0] host_lane = 0;
  logic [2:0] host_addr = 0;
  logic [W-1:0] host_wdata = 0;
  logic [W-1:0] host_rdata;
  logic [L*W-1:0] lane_acc;
  logic [L*3-1:0] lane_idx;
  logic [L-1:0] lane_active;

  simt_pe_array #(.LANES(L), .DATA_W(W), .MEM_DEPTH(D), .NREG(NR)) uut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side model
  int m_acc [L], m_idx [L], m_act [L];
  int m_reg [L][NR];
  int m_mem [L][D];
  int exp_rd;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_lanes(string tag);
    for (int l = 0; l < L; l++) begin
      chk({tag, " acc"}, int'(lane_acc[l*W +: W]), m_acc[l]);
      chk({tag, " idx"}, int'(lane_idx[l*3 +: 3]), m_idx[l]);
      chk({tag, " act"}, int'(lane_active[l]), m_act[l]);
    end
  endtask

  function automatic int cond_hit(int c, int v);
    bit neg = (v >= 32768);
    case (c)
      0: return (v == 0) ? 1 : 0;
      1: return (v != 0) ? 1 : 0;
      2: return neg ? 1 : 0;
      default: return (!neg && v != 0) ? 1 : 0;
    endcase
  endfunction

  // drive one cycle starting at a negedge; model the edge; return at next negedge
  task automatic step(bit v, int op, int sel, int imm, bit hen, bit hwe, int hl, int ha, int hwd);
    ins_valid = v; ins_op = 4'(op); ins_sel = 2'(sel); ins_imm = W'(imm);
    host_en = hen; host_we = hwe; host_lane = 2'(hl); host_addr = 3'(ha); host_wdata = W'(hwd);
    if (hen && !hwe) exp_rd = m_mem[hl][ha];
    for (int l = 0; l < L; l++) begin
      int a0 = m_acc[l];
      int x0 = m_idx[l];
      bit hw = hen && hwe && (hl == l);
      if (v && m_act[l] == 1) begin
        case (op)
          1: m_acc[l] = imm & 16'hFFFF;
          2: m_acc[l] = m_mem[l][x0];
          3: if (!hw) m_mem[l][x0] = a0;
          4: m_acc[l] = (a0 + m_reg[l][sel]) & 16'hFFFF;
          5: m_acc[l] = (a0 - m_reg[l][sel]) & 16'hFFFF;
          6: m_reg[l][sel] = a0;
          7: m_idx[l] = imm % D;
          8: m_idx[l] = (x0 + imm) % D;
          9: m_act[l] = cond_hit(imm % 4, a0);
          default: ;
        endcase
      end
      if (v && op == 10) m_act[l] = 1;
      if (hw) m_mem[l][ha] = hwd & 16'hFFFF;
    end
    @(negedge clk);
    ins_valid = 0; host_en = 0; host_we = 0;
  endtask

  task automatic issue(int op, int sel, int imm);
    step(1, op, sel, imm, 0, 0, 0, 0, 0);
  endtask

  task automatic read_all(string tag);
    for (int l = 0; l < L; l++)
      for (int a = 0; a < D; a++) begin
        step(0, 0, 0, 0, 1, 0, l, a, 0);
        chk(tag, int'(host_rdata), exp_rd);
      end
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int vals [6] = '{0, 1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

  initial begin
    for (int l = 0; l < L; l++) begin
      m_acc[l] = 0; m_idx[l] = 0; m_act[l] = 1;
      for (int r = 0; r < NR; r++) m_reg[l][r] = 0;
      for (int a = 0; a < D; a++) m_mem[l][a] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_lanes("R1 reset");
    chk("R1 rdata reset", int'(host_rdata), 0);

    // R8: host fill and read-back of every word
    for (int l = 0; l < L; l++)
      for (int a = 0; a < D; a++)
        step(0, 0, 0, 0, 1, 1, l, a, l * 37 + a * 5 + 1);
    read_all("R8 host readback");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 rdata hold", int'(host_rdata), exp_rd);

    // R1: data registers start at zero
    for (int r = 0; r < NR; r++) begin
      issue(4, r, 0);
      check_lanes("R1 reg zero");
    end

    // R2: add/subtract sweep with wrap
    foreach (vals[i]) foreach (vals[j]) begin
      issue(1, 0, vals[j]);
      issue(6, 1, 0);
      issue(1, 0, vals[i]);
      issue(4, 1, 0);
      check_lanes("R2 add");
      issue(1, 0, vals[i]);
      issue(5, 1, 0);
      check_lanes("R2 sub");
    end
    issue(13, 0, 16'h7777);
    check_lanes("R2 unused opcode");

    // R4: load through index, every address
    for (int a = 0; a < D; a++) begin
      issue(7, 0, a);
      issue(2, 0, 0);
      check_lanes("R4 load");
    end

    // R6/R5/R7: one-hot masks give each lane its own index
    for (int k = 0; k < L; k++) begin
      issue(10, 0, 0);
      issue(7, 0, 0);
      issue(2, 0, 0);
      issue(6, 0, 0);
      issue(1, 0, k * 37 + 1);
      issue(5, 0, 0);
      issue(9, 0, 0);
      check_lanes("R6 one-hot mask");
      issue(7, 0, k * 3 + 1);
      issue(1, 0, 16'hAB00 + k);
      check_lanes("R5 masked lanes hold");
      issue(10, 0, 0);
      check_lanes("R7 wake all");
    end

    // R3 and R4: per-lane index wrap, load and store
    issue(8, 0, 3);
    check_lanes("R3 addx");
    issue(8, 0, 7);
    check_lanes("R3 addx wrap");
    issue(7, 0, 16'hFFFD);
    check_lanes("R3 setx low bits");
    issue(8, 0, 2);
    issue(2, 0, 0);
    check_lanes("R4 per-lane load");
    issue(1, 0, 16'h0C0C);
    issue(8, 0, 1);
    issue(3, 0, 0);
    read_all("R4 per-lane store");

    // R6: every test code against the value set
    foreach (vals[i]) for (int c = 0; c < 4; c++) begin
      issue(10, 0, 0);
      issue(1, 0, vals[i]);
      issue(9, 0, c);
      check_lanes("R6 compare sweep");
    end

    // R6/R5: nested masking with lane-specific data
    issue(10, 0, 0);
    issue(7, 0, 0);
    step(0, 0, 0, 0, 1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 1, 0, 0);
    step(0, 0, 0, 0, 1, 1, 2, 0, 5);
    step(0, 0, 0, 0, 1, 1, 3, 0, 16'hFFF0);
    issue(2, 0, 0);
    issue(9, 0, 0);
    check_lanes("R6 first mask");
    issue(1, 0, 3);
    check_lanes("R5 ldi under mask");
    issue(9, 0, 1);
    check_lanes("R6 nested mask stays narrow");
    issue(7, 0, 6);
    issue(3, 0, 0);
    read_all("R5 masked store");

    // R10: no valid instruction
    step(0, 1, 0, 16'h5555, 0, 0, 0, 0, 0);
    check_lanes("R10 idle ldi");
    step(0, 10, 0, 0, 0, 0, 0, 0, 0);
    check_lanes("R10 idle wake");

    // R9: host write collides with broadcast store
    issue(10, 0, 0);
    issue(7, 0, 2);
    issue(1, 0, 16'h4242);
    step(1, 3, 0, 0, 1, 1, 1, 2, 16'h9999);
    step(1, 3, 0, 0, 1, 1, 3, 5, 16'h3131);
    read_all("R9 host priority");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule